// File: doc/BRIEF.md
# Serial Shift Register with Parallel Output Latch

This block takes a bit stream on one input and moves it through a chain of shift stages, one stage per rising edge of a shift clock. A separate storage clock copies the whole chain into a storage register in one step. The storage register drives a parallel bus that can be floated. The last stage also leaves the block on a serial output, so several blocks can be chained into one longer register behind a single data pin, as in an SPI-style daisy chain.

The shift chain and the storage register have their own clock and their own state. An active-low clear empties the shift chain at once and has no effect on the storage register, so the parallel bus keeps its pattern while a new one is shifted in. Output enable floats only the parallel bus. The serial output is always driven, which keeps a chain of blocks working while their buses are released. The block has no state machine: every output follows directly from the two registers and the enable.

Top module: `srl_shift_latch`

## Requirements
- R1: On each rising edge of `sh_clk`, `ser_in` enters stage 0 and every stage k moves to stage k+1. Stage k is bit k of the parallel bus after a store, so the first of eight shifted bits appears on `par_q[7]`.
- R2: While `sh_clk` has no rising edge, the shift stages keep their value whatever `ser_in` does.
- R3: A low level on `clr_n` forces every shift stage to 0 at once, without any clock edge, and so drives `ser_out` low.
- R4: The clear never changes the storage register or the value shown on `par_q`.
- R5: On each rising edge of `st_clk`, the storage register takes the shift stage contents. Between those edges it holds, even while shifting goes on.
- R6: With `oe_n` low, `par_q` shows the storage register. With `oe_n` high, all bits of `par_q` are high-impedance.
- R7: `ser_out` always equals the last shift stage, is never high-impedance, and does not depend on `oe_n`.
- R8: When `sh_clk` and `st_clk` rise in the same instant, the storage register takes the contents from before that shift, so it trails the chain by one shift.
- R9: Two blocks chained from `ser_out` to `ser_in` act as one 16-stage register. After 16 shifts of a word, most significant bit first, and one store, the second block's bus holds the upper byte and the first block's bus holds the lower byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_in | input | 1 | Serial data into stage 0 |
| sh_clk | input | 1 | Shift clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| st_clk | input | 1 | Storage clock, rising edge active |
| oe_n | input | 1 | Parallel bus enable, active low |
| par_q | output | STAGES (8) | Storage register contents, high-impedance when disabled |
| ser_out | output | 1 | Last shift stage, always driven |

## Verification
The hardest case to reach is the one where both clocks rise in the same instant, because the stored value then depends on edge order and not on any level. The bench raises both clocks in one statement and checks that the stored byte is the pre-shift pattern, then stores again to see the post-shift pattern. The floating bus cannot be compared against a high-impedance value, so the bench pulls one instance's bus up and the other's down. It then floats each bus while the stored pattern has bits opposite to the pull, so a bus that is still driven shows up as a mismatch.

// File: rtl/srl_pkg.sv
package srl_pkg;

    localparam int unsigned SRL_DEF_STAGES = 8;

    typedef enum logic {
        PAD_DRIVE = 1'b0,
        PAD_FLOAT = 1'b1
    } pad_mode_e;

endpackage

// File: rtl/srl_stage_chain.sv
module srl_stage_chain #(
    parameter int unsigned STAGES = srl_pkg::SRL_DEF_STAGES
) (
    input  logic              sh_clk,
    input  logic              clr_n,
    input  logic              din,
    output logic [STAGES-1:0] q,
    output logic              tap
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] feed;

    // Each stage takes the one below it; stage 0 takes the serial input.
    assign feed = {q[LAST-1:0], din};

    always_ff @(posedge sh_clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= feed;
        end
    end

    assign tap = q[LAST];

endmodule

// File: rtl/srl_hold_reg.sv
module srl_hold_reg #(
    parameter int unsigned STAGES = srl_pkg::SRL_DEF_STAGES
) (
    input  logic              st_clk,
    input  logic [STAGES-1:0] d,
    output logic [STAGES-1:0] q
);
    // No reset: the clear belongs to the shift chain only.
    always_ff @(posedge st_clk) begin
        q <= d;
    end

endmodule

// File: rtl/srl_out_drive.sv
module srl_out_drive #(
    parameter int unsigned STAGES = srl_pkg::SRL_DEF_STAGES
) (
    input  srl_pkg::pad_mode_e mode,
    input  logic [STAGES-1:0]  d,
    output logic [STAGES-1:0]  pad
);
    for (genvar g = 0; g < STAGES; g++) begin : g_pad
        assign pad[g] = (mode == srl_pkg::PAD_DRIVE) ? d[g] : 1'bz;
    end

endmodule

// File: rtl/srl_shift_latch.sv
module srl_shift_latch #(
    parameter int unsigned STAGES = srl_pkg::SRL_DEF_STAGES
) (
    input  logic              ser_in,
    input  logic              sh_clk,
    input  logic              clr_n,
    input  logic              st_clk,
    input  logic              oe_n,
    output logic [STAGES-1:0] par_q,
    output logic              ser_out
);
    logic [STAGES-1:0]  chain_q;
    logic [STAGES-1:0]  hold_q;
    srl_pkg::pad_mode_e pad_mode;

    assign pad_mode = srl_pkg::pad_mode_e'(oe_n);

    srl_stage_chain #(.STAGES(STAGES)) u_chain (
        .sh_clk (sh_clk),
        .clr_n  (clr_n),
        .din    (ser_in),
        .q      (chain_q),
        .tap    (ser_out)
    );

    srl_hold_reg #(.STAGES(STAGES)) u_hold (
        .st_clk (st_clk),
        .d      (chain_q),
        .q      (hold_q)
    );

    srl_out_drive #(.STAGES(STAGES)) u_drive (
        .mode   (pad_mode),
        .d      (hold_q),
        .pad    (par_q)
    );

endmodule

// File: rtl/srl_shift_latch_chk.sv
module srl_shift_latch_chk #(
    parameter int unsigned STAGES = srl_pkg::SRL_DEF_STAGES
) (
    input logic              sh_clk,
    input logic              st_clk,
    input logic              clr_n,
    input logic              ser_out,
    input logic [STAGES-1:0] stages,
    input logic [STAGES-1:0] held
);
    localparam int unsigned LAST = STAGES - 1;

    logic [1:0] sh_cnt;
    logic       st_seen;

    // Shift edges seen since the last clear, saturating at two.
    always_ff @(posedge sh_clk or negedge clr_n) begin
        if (!clr_n) begin
            sh_cnt <= 2'd0;
        end else if (sh_cnt != 2'd2) begin
            sh_cnt <= sh_cnt + 2'd1;
        end
    end

    always_ff @(posedge st_clk or negedge clr_n) begin
        if (!clr_n) begin
            st_seen <= 1'b0;
        end else begin
            st_seen <= 1'b1;
        end
    end

    // R1: each stage holds what the stage below held one shift earlier.
    p_shift_r1: assert property (@(posedge sh_clk) disable iff (!clr_n)
        (sh_cnt == 2'd2) |-> (stages[LAST:1] == $past(stages[LAST-1:0])));

    // R3: while the clear is low, the chain is empty.
    always @(posedge st_clk) begin
        if (!clr_n) begin
            p_clear_r3: assert (stages == '0);
        end
    end

    // R5: the storage register holds the chain value seen at the previous store edge.
    p_capture_r5: assert property (@(posedge st_clk) disable iff (!clr_n)
        st_seen |-> (held == $past(stages)));

    // R7: the serial output follows the next-to-last stage one shift later.
    p_serial_tap_r7: assert property (@(posedge sh_clk) disable iff (!clr_n)
        (sh_cnt == 2'd2) |-> (ser_out == $past(stages[LAST-1])));

endmodule

bind srl_shift_latch srl_shift_latch_chk #(.STAGES(STAGES)) u_chk (
    .sh_clk  (sh_clk),
    .st_clk  (st_clk),
    .clr_n   (clr_n),
    .ser_out (ser_out),
    .stages  (chain_q),
    .held    (hold_q)
);

// File: tb/test_srl_shift_latch.sv
`timescale 1ns/1ps
module test_srl_shift_latch;
    localparam int W = 8;

    logic clk = 1'b0;
    logic ser_in = 1'b0;
    logic sh_clk = 1'b0;
    logic st_clk = 1'b0;
    logic clr_n = 1'b1;
    logic oe_a_n = 1'b0;
    logic oe_b_n = 1'b0;
    wire [W-1:0] par_a;
    wire [W-1:0] par_b;
    wire         ser_a;
    wire         ser_b;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  cmp_on = 1'b0;
    bit  done = 1'b0;

    // Behavioural model: index 0 is the newest bit of the 16-bit chain.
    bit         mdl_q[$];
    logic [W-1:0] mdl_st_a;
    logic [W-1:0] mdl_st_b;

    always #5 clk = ~clk;

    // Bus A floats high, bus B floats low: a released bus reads the pull value.
    for (genvar i = 0; i < W; i++) begin : g_pull
        pullup   (par_a[i]);
        pulldown (par_b[i]);
    end

    srl_shift_latch #(.STAGES(W)) i_srl_shift_latch (
        .ser_in  (ser_in),
        .sh_clk  (sh_clk),
        .clr_n   (clr_n),
        .st_clk  (st_clk),
        .oe_n    (oe_a_n),
        .par_q   (par_a),
        .ser_out (ser_a)
    );

    srl_shift_latch #(.STAGES(W)) i_srl_shift_latch_b (
        .ser_in  (ser_a),
        .sh_clk  (sh_clk),
        .clr_n   (clr_n),
        .st_clk  (st_clk),
        .oe_n    (oe_b_n),
        .par_q   (par_b),
        .ser_out (ser_b)
    );

    function automatic logic [W-1:0] mdl_byte(input int base);
        logic [W-1:0] b;
        for (int i = 0; i < W; i++) b[i] = mdl_q[base + i];
        return b;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic pulse(input bit do_sh, input bit do_st, input bit din);
        @(posedge clk);
        #1 ser_in = din;
        #1;
        if (do_st) begin
            mdl_st_a = mdl_byte(0);
            mdl_st_b = mdl_byte(W);
        end
        if (do_sh) begin
            mdl_q.push_front(din);
            void'(mdl_q.pop_back());
        end
        sh_clk = do_sh;
        st_clk = do_st;
        @(posedge clk);
        #1 sh_clk = 1'b0;
        st_clk = 1'b0;
    endtask

    task automatic do_clear();
        @(posedge clk);
        #2 clr_n = 1'b0;
        for (int i = 0; i < 2*W; i++) mdl_q[i] = 1'b0;
        @(posedge clk);
        #2 clr_n = 1'b1;
    endtask

    task automatic shift_byte(input logic [W-1:0] v);
        for (int i = W-1; i >= 0; i--) pulse(1'b1, 1'b0, v[i]);
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R6 bus A", par_a, oe_a_n ? {W{1'b1}} : mdl_st_a);
            chk("R6 bus B", par_b, oe_b_n ? {W{1'b0}} : mdl_st_b);
            chk("R7 serial A", {7'b0, ser_a}, {7'b0, mdl_q[W-1]});
            chk("R7 serial B", {7'b0, ser_b}, {7'b0, mdl_q[2*W-1]});
        end
    end

    initial begin
        logic [15:0] lf;
        logic [15:0] word;
        for (int i = 0; i < 2*W; i++) mdl_q.push_back(1'b0);
        #1 clr_n = 1'b0;
        #20 clr_n = 1'b1;
        pulse(1'b0, 1'b1, 1'b0);
        cmp_on = 1'b1;

        @(negedge clk);
        chk("R3 reset bus A", par_a, 8'h00);
        chk("R3 reset serial A", {7'b0, ser_a}, 8'h00);

        // R1 and R5: shifting does not reach the bus until a store.
        shift_byte(8'hA5);
        @(negedge clk);
        chk("R5 hold during shift", par_a, 8'h00);
        pulse(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R1 byte order", par_a, 8'hA5);

        // R2: serial input toggles with no shift edge.
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            #1 ser_in = ~ser_in;
        end
        pulse(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R2 no edge no shift", par_a, 8'hA5);

        // R3 and R4: clear empties the chain, bus keeps its pattern.
        do_clear();
        @(negedge clk);
        chk("R3 serial low after clear", {7'b0, ser_a}, 8'h00);
        chk("R4 bus intact after clear", par_a, 8'hA5);
        pulse(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R3 chain empty after clear", par_a, 8'h00);

        // R6 and R7: float the bus, serial output keeps driving.
        shift_byte(8'h3C);
        pulse(1'b0, 1'b1, 1'b0);
        @(posedge clk);
        #1 oe_a_n = 1'b1;
        @(negedge clk);
        chk("R6 bus A floated", par_a, 8'hFF);
        pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        chk("R7 serial driven while floated", {7'b0, ser_a}, 8'h01);
        @(posedge clk);
        #1 oe_a_n = 1'b0;
        @(negedge clk);
        chk("R6 bus A driven again", par_a, 8'h3C);

        // R8: both clocks in one instant capture the pre-shift chain.
        pulse(1'b1, 1'b1, 1'b1);
        @(negedge clk);
        chk("R8 same-edge store", par_a, 8'hF0);
        pulse(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R8 next store", par_a, 8'hE1);

        // R6: bus B floated while its stored pattern has ones.
        @(posedge clk);
        #1 oe_b_n = 1'b1;
        @(negedge clk);
        chk("R6 bus B floated", par_b, 8'h00);
        @(posedge clk);
        #1 oe_b_n = 1'b0;

        // R9: two blocks form one 16-stage register.
        word = 16'h5AC3;
        for (int i = 15; i >= 0; i--) pulse(1'b1, 1'b0, word[i]);
        pulse(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R9 upper byte on second bus", par_b, word[15:8]);
        chk("R9 lower byte on first bus", par_a, word[7:0]);

        // Mixed traffic against the model.
        lf = 16'hACE1;
        for (int i = 0; i < 80; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (i % 23 == 11) do_clear();
            if (i % 9 == 4) begin
                @(posedge clk);
                #1 oe_a_n = lf[3];
                oe_b_n = lf[7];
            end
            pulse(lf[0] | lf[5], (i % 4) == 3 || lf[9], lf[1]);
        end
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule